// File: doc/BRIEF.md
# Programming Strobe Timing Monitor

This block observes the handshake of a one-time-programmable memory write cycle and flags every breach of its timing rules. It samples four inputs on each rising clock edge: an address-stable level, a data-stable level, a programming-supply-enabled level and an active-low programming strobe. Some of the rules count oscillator periods directly. Others are stated in microseconds. A build-time clock-frequency parameter `CLK_KHZ` turns each microsecond limit into a whole number of cycles, rounding up. The intended programming clock lies between 1200 and 6000 kHz.

Each rule has its own sticky flag on `violFlags`. For every strobe cycle, a one-cycle `validCycle` pulse marks a cycle whose hold windows all ended with no breach recorded. The block drives nothing on the programming interface. It is placed beside a programmer, or in a bench, as a passive observer.

Window lengths use these names: `U10 = ceil(10*CLK_KHZ/1000)`, `WMIN = ceil(90*CLK_KHZ/1000)` and `WMAX = ceil(110*CLK_KHZ/1000)`. The address setup limit is `U10+24`, address hold is 48, data setup is 38, data hold is 36, supply setup and hold are both `U10`, and the recovery gap is `U10`. `HEND` is the largest of the three hold limits.

Top module: `prog_timing_monitor`

## Requirements
- R1: After reset, all nine `violFlags` bits are 0 and `validCycle` is 0. Flag bit positions are: 0 address setup, 1 address hold, 2 data setup, 3 data hold, 4 supply setup, 5 supply hold, 6 strobe too short, 7 strobe too long, 8 recovery gap.
- R2: A fall edge is an edge at which `progN` is sampled low after being sampled high. At a fall edge, each level input must have been sampled high at no fewer than its setup limit of consecutive preceding edges. Otherwise its setup bit (0, 2 or 4) sets.
- R3: The rise edge is hold edge 0. Each level input must be sampled high at hold edges 0 to L-1, where L is its hold limit. A low sample in that range sets its hold bit (1, 3 or 5).
- R4: At a rise edge, if the strobe was sampled low at fewer than `WMIN` edges, bit 6 sets.
- R5: Bit 7 sets at the edge where the strobe is sampled low for the (`WMAX`+1)th consecutive time, while the strobe is still low.
- R6: After at least one rise, bit 8 sets at a fall edge if the strobe was sampled high at fewer than `U10` edges since the latest rise.
- R7: Every flag stays set until reset. A later clean cycle clears no flag.
- R8: `validCycle` is high for exactly the one cycle after hold edge `HEND`-1. It rises only if no flag bit was newly set since the previous such verdict edge (or since reset), including at that edge. This holds even while older sticky flags remain set.
- R9: Microsecond limits round up. At `CLK_KHZ`=1250, `U10`=13, `WMIN`=113 and `WMAX`=138.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock at `CLK_KHZ` |
| rstN | input | 1 | Active-low synchronous reset |
| addrValid | input | 1 | High while the address is stable |
| dataValid | input | 1 | High while the data is stable |
| vppOn | input | 1 | High while the programming supply is enabled |
| progN | input | 1 | Programming strobe, active low |
| violFlags | output | 9 | Sticky breach flags, one per rule (see R1) |
| validCycle | output | 1 | One-cycle pulse for a clean completed cycle |

## Verification
The main cycle is driven from a table. Each row moves one setup count, strobe width or hold count to one side of its limit, so each flag bit is shown to answer only to its own rule. The rows include exact-limit and one-short cases, which separate a strict comparison from an inclusive one. Row 3 puts the supply setup at 12 against a rounded limit of 13, which distinguishes rounding up from truncation. Directed runs place a second strobe fall 12 and 13 edges after a rise, check the long-width flag on the 138th and 139th low samples, and follow a failed cycle with a clean one to separate the sticky flag from the per-cycle pulse.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

  localparam int NUM_RULES     = 9;
  localparam int NUM_LEVELS    = 3;
  localparam int ADDR_EXTRA    = 24;
  localparam int ADDR_HOLD_CYC = 48;
  localparam int DATA_SU_CYC   = 38;
  localparam int DATA_HOLD_CYC = 36;
  localparam int US_SETTLE     = 10;
  localparam int US_WIDTH_MIN  = 90;
  localparam int US_WIDTH_MAX  = 110;

  // strobes from control to datapath
  typedef struct packed {
    logic startLow;   // fall edge: low counter restarts at 1
    logic contLow;    // strobe still low: low counter advances
    logic startPost;  // rise edge: post-rise counter restarts at 1
  } ctlStrobes_t;

  function automatic int usToCycles(input int us, input int khz);
    return (us * khz + 999) / 1000;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ptm_datapath.sv
module ptm_datapath
  import ptm_pkg::*;
#(
  parameter int RUN_SAT  = 38,
  parameter int LOW_SAT  = 661,
  parameter int POST_SAT = 60,
  localparam int RW = $clog2(RUN_SAT + 1),
  localparam int LW = $clog2(LOW_SAT + 1),
  localparam int PW = $clog2(POST_SAT + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_LEVELS-1:0]         levels,
  input  ctlStrobes_t                   strb,
  output logic [NUM_LEVELS-1:0][RW-1:0] runCnt,
  output logic [LW-1:0]                 lowCnt,
  output logic [PW-1:0]                 postCnt
);

  // consecutive-high counters, one per level input
  for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_run
    always_ff @(posedge clk) begin
      if (!rstN || !levels[i]) begin
        runCnt[i] <= '0;
      end else if (runCnt[i] != RW'(RUN_SAT)) begin
        runCnt[i] <= runCnt[i] + 1'b1;
      end
    end
  end

  // strobe-low sample counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (strb.startLow) begin
      lowCnt <= LW'(1);
    end else if (strb.contLow && lowCnt != LW'(LOW_SAT)) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  // edges since the latest rise, free running until saturated
  always_ff @(posedge clk) begin
    if (!rstN) begin
      postCnt <= '0;
    end else if (strb.startPost) begin
      postCnt <= PW'(1);
    end else if (postCnt != PW'(POST_SAT)) begin
      postCnt <= postCnt + 1'b1;
    end
  end

endmodule

// File: rtl/ptm_control.sv
module ptm_control
  import ptm_pkg::*;
#(
  parameter int ADDR_SU  = 84,
  parameter int DATA_SU  = 38,
  parameter int VPP_SU   = 60,
  parameter int ADDR_HD  = 48,
  parameter int DATA_HD  = 36,
  parameter int VPP_HD   = 60,
  parameter int W_MIN    = 540,
  parameter int W_MAX    = 660,
  parameter int GAP      = 60,
  parameter int HOLD_END = 60,
  parameter int RUN_SAT  = 84,
  parameter int LOW_SAT  = 661,
  parameter int POST_SAT = 60,
  localparam int RW = $clog2(RUN_SAT + 1),
  localparam int LW = $clog2(LOW_SAT + 1),
  localparam int PW = $clog2(POST_SAT + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          progN,
  input  logic [NUM_LEVELS-1:0]         levels,
  input  logic [NUM_LEVELS-1:0][RW-1:0] runCnt,
  input  logic [LW-1:0]                 lowCnt,
  input  logic [PW-1:0]                 postCnt,
  output ctlStrobes_t                   strb,
  output logic [NUM_RULES-1:0]          violFlags,
  output logic                          validCycle
);

  localparam int SU_LIM [NUM_LEVELS] = '{ADDR_SU, DATA_SU, VPP_SU};
  localparam int HD_LIM [NUM_LEVELS] = '{ADDR_HD, DATA_HD, VPP_HD};

  logic                  progQ;
  logic                  armed;
  logic                  cycBad;
  logic                  fall, rise, contLow, verdict;
  logic [NUM_LEVELS-1:0] suViol, hdViol;
  logic                  shortViol, longViol, gapViol;
  logic [NUM_RULES-1:0]  viol;

  assign fall    = progQ & ~progN;
  assign rise    = ~progQ & progN;
  assign contLow = ~progQ & ~progN;

  assign strb.startLow  = fall;
  assign strb.contLow   = contLow;
  assign strb.startPost = rise;

  for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_lvl
    assign suViol[i] = fall & (runCnt[i] < RW'(SU_LIM[i]));
    assign hdViol[i] = ~levels[i] &
                       (rise | (armed & (postCnt < PW'(HD_LIM[i]))));
  end

  assign shortViol = rise & (lowCnt < LW'(W_MIN));
  assign longViol  = contLow & (lowCnt >= LW'(W_MAX));
  assign gapViol   = fall & armed & (postCnt < PW'(GAP));

  assign viol = {gapViol, longViol, shortViol,
                 hdViol[2], suViol[2], hdViol[1], suViol[1],
                 hdViol[0], suViol[0]};

  assign verdict = armed & ~rise & (postCnt == PW'(HOLD_END - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progQ      <= 1'b1;
      armed      <= 1'b0;
      cycBad     <= 1'b0;
      violFlags  <= '0;
      validCycle <= 1'b0;
    end else begin
      progQ      <= progN;
      armed      <= armed | rise;
      violFlags  <= violFlags | viol;
      validCycle <= verdict & ~cycBad & ~(|viol);
      cycBad     <= verdict ? 1'b0 : (cycBad | (|viol));
    end
  end

endmodule

// File: rtl/prog_timing_monitor.sv
module prog_timing_monitor
  import ptm_pkg::*;
#(
  parameter int CLK_KHZ = 6000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 addrValid,
  input  logic                 dataValid,
  input  logic                 vppOn,
  input  logic                 progN,
  output logic [NUM_RULES-1:0] violFlags,
  output logic                 validCycle
);

  localparam int U10      = usToCycles(US_SETTLE, CLK_KHZ);
  localparam int ADDR_SU  = U10 + ADDR_EXTRA;
  localparam int W_MIN    = usToCycles(US_WIDTH_MIN, CLK_KHZ);
  localparam int W_MAX    = usToCycles(US_WIDTH_MAX, CLK_KHZ);
  localparam int HOLD_END = max2(max2(ADDR_HOLD_CYC, DATA_HOLD_CYC), U10);
  localparam int RUN_SAT  = max2(max2(ADDR_SU, DATA_SU_CYC), U10);
  localparam int LOW_SAT  = W_MAX + 1;
  localparam int POST_SAT = max2(HOLD_END, U10);
  localparam int RW       = $clog2(RUN_SAT + 1);
  localparam int LW       = $clog2(LOW_SAT + 1);
  localparam int PW       = $clog2(POST_SAT + 1);

  logic [NUM_LEVELS-1:0]         levels;
  logic [NUM_LEVELS-1:0][RW-1:0] runCnt;
  logic [LW-1:0]                 lowCnt;
  logic [PW-1:0]                 postCnt;
  ctlStrobes_t                   strb;

  assign levels = {vppOn, dataValid, addrValid};

  ptm_datapath #(
    .RUN_SAT (RUN_SAT),
    .LOW_SAT (LOW_SAT),
    .POST_SAT(POST_SAT)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .levels (levels),
    .strb   (strb),
    .runCnt (runCnt),
    .lowCnt (lowCnt),
    .postCnt(postCnt)
  );

  ptm_control #(
    .ADDR_SU (ADDR_SU),
    .DATA_SU (DATA_SU_CYC),
    .VPP_SU  (U10),
    .ADDR_HD (ADDR_HOLD_CYC),
    .DATA_HD (DATA_HOLD_CYC),
    .VPP_HD  (U10),
    .W_MIN   (W_MIN),
    .W_MAX   (W_MAX),
    .GAP     (U10),
    .HOLD_END(HOLD_END),
    .RUN_SAT (RUN_SAT),
    .LOW_SAT (LOW_SAT),
    .POST_SAT(POST_SAT)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .progN     (progN),
    .levels    (levels),
    .runCnt    (runCnt),
    .lowCnt    (lowCnt),
    .postCnt   (postCnt),
    .strb      (strb),
    .violFlags (violFlags),
    .validCycle(validCycle)
  );

endmodule

// File: rtl/ptm_checker.sv
module ptm_checker
  import ptm_pkg::*;
#(
  parameter int CLK_KHZ = 6000
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 addrValid,
  input logic                 vppOn,
  input logic                 progN,
  input logic [NUM_RULES-1:0] violFlags,
  input logic                 validCycle
);

  localparam int WMAX   = usToCycles(US_WIDTH_MAX, CLK_KHZ);
  localparam int LR_SAT = WMAX + 1;
  localparam int LRW    = $clog2(LR_SAT + 1);

  logic [LRW-1:0] lowRun;

  // independent count of consecutive low strobe samples
  always_ff @(posedge clk) begin
    if (!rstN || progN) begin
      lowRun <= '0;
    end else if (lowRun != LRW'(LR_SAT)) begin
      lowRun <= lowRun + 1'b1;
    end
  end

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((violFlags & $past(violFlags)) == $past(violFlags)));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    validCycle |=> !validCycle);

  a_r8_pulse_clean: assert property (@(posedge clk) disable iff (!rstN)
    validCycle |-> $stable(violFlags));

  a_r5_long_flagged: assert property (@(posedge clk) disable iff (!rstN)
    (lowRun == LRW'(LR_SAT)) |-> violFlags[7]);

  a_r2_vpp_setup: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !progN && $past(progN) && !$past(vppOn)) |=> violFlags[4]);

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && progN && !$past(progN) && !addrValid) |=> violFlags[1]);

endmodule

bind prog_timing_monitor ptm_checker #(.CLK_KHZ(CLK_KHZ)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .addrValid (addrValid),
  .vppOn     (vppOn),
  .progN     (progN),
  .violFlags (violFlags),
  .validCycle(validCycle)
);

// File: tb/test_prog_timing_monitor.sv
module test_prog_timing_monitor;

  // At 1250 kHz: U10=13, WMIN=113, WMAX=138, address setup 37
  localparam int KHZ = 1250;
  localparam int NV  = 12;
  // aSu, dSu, vSu, width, aHold, dHold, vHold, expected flags, expected pulses
  localparam int VEC [NV][9] = '{
    '{37, 38, 13, 113, 48, 36, 13, 'h000, 1},
    '{36, 38, 13, 113, 48, 36, 13, 'h001, 0},
    '{37, 37, 13, 113, 48, 36, 13, 'h004, 0},
    '{37, 38, 12, 113, 48, 36, 13, 'h010, 0},
    '{37, 38, 13, 112, 48, 36, 13, 'h040, 0},
    '{37, 38, 13, 138, 48, 36, 13, 'h000, 1},
    '{37, 38, 13, 139, 48, 36, 13, 'h080, 0},
    '{37, 38, 13, 113, 47, 36, 13, 'h002, 0},
    '{37, 38, 13, 113, 48, 35, 13, 'h008, 0},
    '{37, 38, 13, 113, 48, 36, 12, 'h020, 0},
    '{60, 60, 60, 120, 60, 60, 60, 'h000, 1},
    '{10, 38, 13, 113, 48, 36,  0, 'h021, 0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       addrValid = 1'b0;
  logic       dataValid = 1'b0;
  logic       vppOn = 1'b0;
  logic       progN = 1'b1;
  logic [8:0] violFlags;
  logic       validCycle;

  int nChecks = 0;
  int nFail   = 0;
  int pulseCnt = 0;

  always #10 clk = ~clk;

  prog_timing_monitor #(.CLK_KHZ(KHZ)) i_prog_timing_monitor (
    .clk       (clk),
    .rstN      (rstN),
    .addrValid (addrValid),
    .dataValid (dataValid),
    .vppOn     (vppOn),
    .progN     (progN),
    .violFlags (violFlags),
    .validCycle(validCycle)
  );

  always @(negedge clk) if (rstN && validCycle) pulseCnt++;

  task automatic stepEdge();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkEq(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    addrValid = 1'b0; dataValid = 1'b0; vppOn = 1'b0; progN = 1'b1;
    repeat (3) stepEdge();
    rstN = 1'b1;
    stepEdge();
    pulseCnt = 0;
  endtask

  task automatic runCycle(input int aSu, input int dSu, input int vSu,
                          input int w, input int aH, input int dH, input int vH);
    int s;
    s = aSu;
    if (dSu > s) s = dSu;
    if (vSu > s) s = vSu;
    for (int i = 1; i <= s; i++) begin
      addrValid = (i > s - aSu);
      dataValid = (i > s - dSu);
      vppOn     = (i > s - vSu);
      stepEdge();
    end
    progN = 1'b0;
    repeat (w) stepEdge();
    progN = 1'b1;
    addrValid = (aH > 0); dataValid = (dH > 0); vppOn = (vH > 0);
    for (int k = 1; k <= 60; k++) begin
      stepEdge();
      addrValid = (k < aH); dataValid = (k < dH); vppOn = (k < vH);
    end
    addrValid = 1'b0; dataValid = 1'b0; vppOn = 1'b0;
    repeat (5) stepEdge();
  endtask

  task automatic gapTest(input int g);
    doReset();
    addrValid = 1'b1; dataValid = 1'b1; vppOn = 1'b1;
    repeat (40) stepEdge();
    progN = 1'b0;
    repeat (113) stepEdge();
    progN = 1'b1;
    repeat (g) stepEdge();
    progN = 1'b0;
    stepEdge();
    // R6: bit 8 only when the high gap is below 13 edges
    checkEq($sformatf("R6 gap %0d flags", g), int'(violFlags), (g < 13) ? 'h100 : 'h000);
    progN = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    // R1: reset state
    doReset();
    checkEq("R1 reset flags", int'(violFlags), 0);
    checkEq("R1 reset validCycle", int'(validCycle), 0);

    // R2 R3 R4 R5 R8 R9: table of single-rule cases
    for (int v = 0; v < NV; v++) begin
      doReset();
      runCycle(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3],
               VEC[v][4], VEC[v][5], VEC[v][6]);
      checkEq($sformatf("R2/R3/R4/R5/R9 row %0d flags", v), int'(violFlags), VEC[v][7]);
      checkEq($sformatf("R8 row %0d pulses", v), pulseCnt, VEC[v][8]);
    end

    // R6: recovery gap just below and at the limit
    gapTest(12);
    gapTest(13);

    // R5: long flag rises while strobe is still low, on the 139th sample
    doReset();
    addrValid = 1'b1; dataValid = 1'b1; vppOn = 1'b1;
    repeat (40) stepEdge();
    progN = 1'b0;
    repeat (138) stepEdge();
    checkEq("R5 after 138 low samples bit7", int'(violFlags[7]), 0);
    stepEdge();
    checkEq("R5 after 139 low samples bit7", int'(violFlags[7]), 1);
    progN = 1'b1;

    // R7 R8: failed cycle, then a clean one
    doReset();
    runCycle(36, 38, 13, 113, 48, 36, 13);
    checkEq("R8 failed cycle no pulse", pulseCnt, 0);
    pulseCnt = 0;
    runCycle(37, 38, 13, 113, 48, 36, 13);
    checkEq("R7 flag kept after clean cycle", int'(violFlags), 'h001);
    checkEq("R8 clean cycle pulses once", pulseCnt, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule